// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a handful of recently used page mappings and answers translation lookups in the same cycle they are presented. A 32-bit virtual address splits into a 20-bit virtual page number and a 12-bit offset. Only the page number reaches this block. Each lookup compares that number against the tag of every stored entry in parallel. A single match returns the physical page number, the access-rights field, and the dirty and reference flags of that entry.

When nothing matches, the block raises a miss. The requester then performs the page table walk outside this block and writes the result back through the refill port. A refill takes the lowest-numbered empty slot first. When every slot is occupied, a round-robin pointer picks the slot to replace.

Status flags change as entries are used. Any hit sets the reference flag, and a hit on a write access also sets the dirty flag. A separate marking port can set either flag by page number. A flush input empties the whole array in one cycle. If two entries ever hold the same page number, the lookup reports an error instead of returning a frame.

Top module: `xlate_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid, so any lookup reports a miss.
- R2: A lookup (`lk_valid`=1) whose page number matches exactly one valid entry raises `lk_hit` in the same cycle. In that cycle it returns that entry's `lk_ppn`, `lk_rights`, `lk_dirty` and `lk_ref` as they were stored before the cycle, and `lk_miss`=0.
- R3: A lookup whose page number matches no valid entry raises `lk_miss`, which asks for a page table walk. `lk_hit` stays 0 and the data outputs are zero.
- R4: A hit sets the matching entry's reference flag, and a hit with `lk_write`=1 also sets its dirty flag. Both changes are visible from the next cycle.
- R5: `mark_en`=1 sets the dirty flag (when `mark_dirty`=1) and the reference flag (when `mark_ref`=1) of every valid entry whose tag equals `mark_vpn`. It has no effect when no entry matches.
- R6: A refill (`fill_en`=1) writes tag, frame and rights into the lowest-indexed invalid entry, marks it valid, and clears its dirty and reference flags. The new entry can be looked up from the next cycle.
- R7: When all entries are valid, a refill replaces the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, only when it is used. A flush does not move it.
- R8: `flush`=1 invalidates every entry at the next clock edge. A lookup in the flush cycle reports `lk_miss`=1 and `lk_hit`=0 and updates nothing. A refill in the flush cycle is discarded.
- R9: A lookup that matches more than one valid entry raises `lk_multi`, with `lk_hit`=0, `lk_miss`=0, all data outputs zero, and no flag updates.
- R10: With `lk_valid`=0, `lk_hit`, `lk_miss`, `lk_multi` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No match; page table walk required |
| lk_multi | output | 1 | More than one entry matched (error) |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_rights | output | RIGHTS_W | Access rights of the hit |
| lk_dirty | output | 1 | Stored dirty flag of the hit |
| lk_ref | output | 1 | Stored reference flag of the hit |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_rights | input | RIGHTS_W | Refill access rights |
| mark_en | input | 1 | Flag-marking request |
| mark_vpn | input | VPN_W | Page number to mark |
| mark_dirty | input | 1 | Set dirty flag on match |
| mark_ref | input | 1 | Set reference flag on match |

## Verification
A corrupted valid vector or tag shows up on the very next lookup of the affected page: a stored page misses, an evicted page still hits, or a duplicate raises `lk_multi`. A lost flag update shows on the next cycle's lookup, because `lk_dirty` and `lk_ref` reflect stored state directly. A wrong replacement pointer is not visible until the array is full. It is caught one cycle after the refill that evicts the wrong page, so the bench fills the array completely, flushes, and refills it to expose the pointer's history.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int DEF_ENTRIES  = 16;
  localparam int DEF_VPN_W    = 20;
  localparam int DEF_PPN_W    = 20;
  localparam int DEF_RIGHTS_W = 3;

  typedef struct packed {
    logic dirty;
    logic refd;
  } ent_flags_t;
endpackage

// File: rtl/xlc_match.sv
module xlc_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          any_hit,
  output logic                          multi_hit
);
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  assign any_hit   = |hit_vec;
  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_hit = |(hit_vec & (hit_vec - ENTRIES'(1)));
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               fill_fire,
  output logic [IDX_W-1:0]   victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign victim = free_found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_fire && !free_found) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/xlc_readmux.sv
module xlc_readmux #(
  parameter int ENTRIES = 16,
  parameter int W       = 8
) (
  input  logic [ENTRIES-1:0]        sel,
  input  logic [ENTRIES-1:0][W-1:0] data,
  output logic [W-1:0]              dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      dout |= data[i] & {W{sel[i]}};
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int ENTRIES  = DEF_ENTRIES,
  parameter int VPN_W    = DEF_VPN_W,
  parameter int PPN_W    = DEF_PPN_W,
  parameter int RIGHTS_W = DEF_RIGHTS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                lk_valid,
  input  logic                lk_write,
  input  logic [VPN_W-1:0]    lk_vpn,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic                lk_multi,
  output logic [PPN_W-1:0]    lk_ppn,
  output logic [RIGHTS_W-1:0] lk_rights,
  output logic                lk_dirty,
  output logic                lk_ref,
  input  logic                fill_en,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [RIGHTS_W-1:0] fill_rights,
  input  logic                mark_en,
  input  logic [VPN_W-1:0]    mark_vpn,
  input  logic                mark_dirty,
  input  logic                mark_ref
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int REC_W = PPN_W + RIGHTS_W + 2;

  // entry storage
  logic [ENTRIES-1:0][VPN_W-1:0]    tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_q;
  logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q;
  logic [ENTRIES-1:0]               valid_q;
  logic [ENTRIES-1:0]               dirty_q;
  logic [ENTRIES-1:0]               ref_q;

  logic [ENTRIES-1:0] lk_vec, mk_vec;
  logic               lk_any, lk_many, mk_any, mk_many;
  logic [IDX_W-1:0]   victim;
  logic               fill_fire, lk_single, lk_upd;

  xlc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lookup_cmp (
    .key(lk_vpn), .valid(valid_q), .tags(tag_q),
    .hit_vec(lk_vec), .any_hit(lk_any), .multi_hit(lk_many)
  );

  xlc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_mark_cmp (
    .key(mark_vpn), .valid(valid_q), .tags(tag_q),
    .hit_vec(mk_vec), .any_hit(mk_any), .multi_hit(mk_many)
  );

  assign fill_fire = fill_en && !flush;

  xlc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid(valid_q),
    .fill_fire(fill_fire), .victim(victim)
  );

  // lookup result
  assign lk_single = lk_valid && !flush && lk_any && !lk_many;
  assign lk_hit    = lk_single;
  assign lk_multi  = lk_valid && !flush && lk_many;
  assign lk_miss   = lk_valid && (flush || !lk_any);
  assign lk_upd    = lk_single;

  logic [ENTRIES-1:0][REC_W-1:0] rec;
  logic [REC_W-1:0]              rec_out;
  ent_flags_t                    out_flags;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_rec
      assign rec[g] = {ppn_q[g], rights_q[g], dirty_q[g], ref_q[g]};
    end
  endgenerate

  xlc_readmux #(.ENTRIES(ENTRIES), .W(REC_W)) u_rmux (
    .sel(lk_single ? lk_vec : '0), .data(rec), .dout(rec_out)
  );

  assign {lk_ppn, lk_rights, out_flags} = rec_out;
  assign lk_dirty = out_flags.dirty;
  assign lk_ref   = out_flags.refd;

  // address-pair storage: written only by refill, no reset
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[victim]    <= fill_vpn;
      ppn_q[victim]    <= fill_ppn;
      rights_q[victim] <= fill_rights;
    end
  end

  // valid and status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (lk_upd && lk_vec[i]) begin
          ref_q[i] <= 1'b1;
          if (lk_write) dirty_q[i] <= 1'b1;
        end
        if (mark_en && mk_vec[i]) begin
          if (mark_dirty) dirty_q[i] <= 1'b1;
          if (mark_ref)   ref_q[i]   <= 1'b1;
        end
        if (fill_fire && (victim == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
          ref_q[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker #(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int RIGHTS_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                flush,
  input logic                lk_valid,
  input logic                lk_write,
  input logic [VPN_W-1:0]    lk_vpn,
  input logic                lk_hit,
  input logic                lk_miss,
  input logic                lk_multi,
  input logic [PPN_W-1:0]    lk_ppn,
  input logic [RIGHTS_W-1:0] lk_rights,
  input logic                lk_dirty,
  input logic                lk_ref,
  input logic                fill_en
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit && !lk_multi);

  assert_hit_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !lk_miss && !lk_multi);

  assert_ref_sticks_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !flush && !fill_en) |=>
      (!(lk_valid && !flush && lk_vpn == $past(lk_vpn)) || (lk_hit && lk_ref)));

  assert_dirty_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_write && !flush && !fill_en) |=>
      (!(lk_valid && !flush && lk_vpn == $past(lk_vpn)) || (lk_hit && lk_dirty)));

  assert_flush_cycle_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && flush) |-> lk_miss && !lk_hit);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit && !lk_multi);

  assert_multi_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> !lk_hit && !lk_miss && lk_ppn == '0 && lk_rights == '0 && !lk_dirty && !lk_ref);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit && !lk_miss && !lk_multi && lk_ppn == '0);
endmodule

bind xlate_cache xlc_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
  .lk_ppn(lk_ppn), .lk_rights(lk_rights), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
  .fill_en(fill_en)
);

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 0, lk_valid = 0, lk_write = 0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit, lk_miss, lk_multi, lk_dirty, lk_ref;
  logic [19:0] lk_ppn;
  logic [2:0]  lk_rights;
  logic        fill_en = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [2:0]  fill_rights = '0;
  logic        mark_en = 0, mark_dirty = 0, mark_ref = 0;
  logic [19:0] mark_vpn = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlate_cache uut (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
    .lk_ppn(lk_ppn), .lk_rights(lk_rights), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rights(fill_rights),
    .mark_en(mark_en), .mark_vpn(mark_vpn), .mark_dirty(mark_dirty), .mark_ref(mark_ref)
  );

  function automatic logic [19:0] frame_of(input logic [19:0] v);
    return v ^ 20'hA5C3F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; lk_valid = 0; lk_write = 0; fill_en = 0; mark_en = 0;
    mark_dirty = 0; mark_ref = 0;
  endtask

  // new cycle: inputs change just after the falling edge
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic fill(input logic [19:0] v, input logic [2:0] r);
    cyc();
    fill_en = 1; fill_vpn = v; fill_ppn = frame_of(v); fill_rights = r;
  endtask

  // lookup, sampled mid-cycle; results as {hit,miss,multi,dirty,ref}
  task automatic look(input logic [19:0] v, input bit wr);
    cyc();
    lk_valid = 1; lk_vpn = v; lk_write = wr;
    #1;
  endtask

  task automatic expect_hit(input logic [19:0] v, input bit d, input bit rf, input string req);
    look(v, 0);
    check(lk_hit && !lk_miss && !lk_multi, req, {29'd0, lk_hit, lk_miss, lk_multi}, 32'h4);
    check(lk_ppn == frame_of(v) && lk_dirty == d && lk_ref == rf, req,
          {10'd0, lk_ppn, lk_dirty, lk_ref}, {10'd0, frame_of(v), d, rf});
  endtask

  task automatic expect_miss(input logic [19:0] v, input string req);
    look(v, 0);
    check(!lk_hit && lk_miss && !lk_multi && lk_ppn == 0, req,
          {9'd0, lk_hit, lk_miss, lk_multi, lk_ppn}, {12'h2, 20'h0});
  endtask

  task automatic t_reset();
    cyc(); #1;
    check(!lk_hit && !lk_miss && !lk_multi && lk_ppn == 0 && !lk_dirty && !lk_ref,
          "R10 idle outputs", {lk_hit, lk_miss, lk_multi, lk_ppn}, 0);
    expect_miss(20'h00000, "R1 reset empty vpn 0");
    expect_miss(20'h12345, "R1 reset empty vpn 12345");
  endtask

  task automatic t_hit_flags();
    fill(20'h12345, 3'd5);
    look(20'h12345, 0);
    check(lk_hit && lk_rights == 3'd5, "R2 hit rights", {lk_hit, lk_rights}, {1'b1, 3'd5});
    check(!lk_dirty && !lk_ref && lk_ppn == frame_of(20'h12345), "R6 fresh entry flags clear",
          {lk_dirty, lk_ref, lk_ppn}, {2'b00, frame_of(20'h12345)});
    expect_hit(20'h12345, 0, 1, "R4 ref set after hit");
    look(20'h12345, 1);
    check(lk_hit && !lk_dirty, "R4 write hit shows old dirty", {lk_hit, lk_dirty}, 2'b10);
    expect_hit(20'h12345, 1, 1, "R4 dirty set after write hit");
    expect_miss(20'h12346, "R3 neighbour page misses");
  endtask

  task automatic t_mark();
    fill(20'h00077, 3'd2);
    cyc(); mark_en = 1; mark_vpn = 20'h00077; mark_dirty = 1; mark_ref = 0;
    look(20'h00077, 0);
    check(lk_hit && lk_dirty && !lk_ref, "R5 mark dirty only", {lk_dirty, lk_ref}, 2'b10);
    cyc(); mark_en = 1; mark_vpn = 20'h99999; mark_dirty = 1; mark_ref = 1;
    expect_miss(20'h99999, "R5 mark without match has no effect");
  endtask

  task automatic t_flush();
    cyc();
    flush = 1; lk_valid = 1; lk_vpn = 20'h12345;
    fill_en = 1; fill_vpn = 20'h55555; fill_ppn = frame_of(20'h55555);
    #1;
    check(lk_miss && !lk_hit, "R8 lookup in flush cycle misses", {lk_hit, lk_miss}, 2'b01);
    expect_miss(20'h12345, "R8 entry gone after flush");
    expect_miss(20'h00077, "R8 second entry gone after flush");
    expect_miss(20'h55555, "R8 refill in flush cycle discarded");
  endtask

  task automatic t_multi();
    fill(20'h0AAAA, 3'd1);
    cyc(); fill_en = 1; fill_vpn = 20'h0AAAA; fill_ppn = 20'h00002; fill_rights = 3'd7;
    look(20'h0AAAA, 1);
    check(lk_multi && !lk_hit && !lk_miss && lk_ppn == 0 && lk_rights == 0,
          "R9 duplicate tag raises error", {lk_multi, lk_hit, lk_miss, lk_ppn}, {3'b100, 20'h0});
    cyc(); flush = 1;
  endtask

  task automatic t_replace();
    // rr pointer is still 0: every fill so far went into an empty slot
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 3'd3);
    expect_hit(20'h00100, 0, 0, "R6 first fill stored");
    expect_hit(20'h0010F, 0, 0, "R6 last fill stored");
    fill(20'h00200, 3'd3);
    expect_miss(20'h00100, "R7 full array evicts slot 0");
    expect_hit(20'h00101, 0, 0, "R7 slot 1 kept");
    expect_hit(20'h00200, 0, 0, "R7 replacement visible");
    fill(20'h00201, 3'd3);
    expect_miss(20'h00101, "R7 pointer advanced to slot 1");
    cyc(); flush = 1;
    for (int i = 0; i < N; i++) fill(20'h00300 + 20'(i), 3'd3);
    fill(20'h00400, 3'd3);
    expect_miss(20'h00302, "R7 pointer kept across flush");
    expect_hit(20'h00300, 0, 0, "R6 lowest free slot refilled first");
    expect_hit(20'h00301, 0, 0, "R7 slot 1 kept after flush");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_hit_flags();
    t_mark();
    t_flush();
    t_multi();
    t_replace();
    cyc();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule